// File: doc/BRIEF.md
# PCM Byte-Stream Channel Assembler

This block takes PCM audio arriving one byte at a time on an 8-bit write port and rebuilds whole samples from it. Configuration inputs set the number of bytes per sample (1 to 3) and the number of interleaved channels (1 to 8). Each completed sample is placed in an internal FIFO, left-justified in a 24-bit word and tagged with its channel number. Channel 0 is the left channel.

A software-driven alignment input resets the byte and channel position. While it is high, written bytes are discarded. Once it returns low, the next byte is taken as the first byte of channel 0. The host uses this before it starts a transfer, or to recover after a lost byte.

A registered level flag compares the FIFO fill against a programmable threshold. The host checks it before sending each block of bytes. The flag tracks the fill continuously, so it can change part way through a block. A byte written while the FIFO is full is thrown away and sets a sticky overflow bit.

Top module: `pcm_stream_assembler`

## Requirements
- R1: While `sync_ctl` is high, `wr_en` bytes are ignored and the byte/channel position returns to zero. The first byte written after `sync_ctl` falls is byte 0 of channel 0.
- R2: `cfg_bytes` selects the bytes per sample: 1, 2 or 3. A value of 0 acts as 1. Bytes within one sample arrive most-significant first.
- R3: Samples are left-justified in the 24-bit `rd_sample`, with unused low bits zero. One-byte samples occupy bits 23:16. Two-byte samples occupy bits 23:8.
- R4: Consecutive samples carry channel tags 0, 1, … up to `cfg_chans_m1`, in write order.
- R5: After the last byte of channel `cfg_chans_m1`, the next byte starts channel 0 again, with no new sync needed.
- R6: The FIFO returns samples oldest first. A cycle with `rd_en` high and the FIFO non-empty gives `rd_valid` high on the next cycle, with that sample on `rd_sample` and `rd_chan`. With `rd_en` high on an empty FIFO, `rd_valid` stays low.
- R7: `level_flag` is high when the FIFO fill is at or above `cfg_thresh`, and low when it is below. It is registered, so it reflects the fill one clock later. It can change between the bytes of a block.
- R8: A byte written while the FIFO holds `FIFO_DEPTH` samples is dropped. It does not advance the byte/channel position.
- R9: A dropped byte sets `overflow`, which stays high until `sync_ctl` is driven high.
- R10: After reset, `rd_valid`, `level_flag` (for a non-zero threshold) and `overflow` are low, and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bytes | input | 2 | Bytes per sample (1..3, 0 acts as 1) |
| cfg_chans_m1 | input | 3 | Channel count minus one |
| cfg_thresh | input | 5 | FIFO fill threshold for `level_flag` |
| sync_ctl | input | 1 | Alignment control; high discards bytes and resets position |
| wr_en | input | 1 | Byte write strobe |
| wr_byte | input | 8 | Byte data |
| rd_en | input | 1 | FIFO pop request |
| rd_valid | output | 1 | Popped sample valid (cycle after `rd_en`) |
| rd_sample | output | 24 | Left-justified sample |
| rd_chan | output | 3 | Channel tag of the sample |
| level_flag | output | 1 | Fill at or above threshold |
| overflow | output | 1 | Sticky dropped-byte indicator |

## Verification
The main sweep covers every combination of sample width and channel count. Each run writes two full frames, then reads the FIFO back in full. This separates errors in byte order, in justification and in channel wrap from one another.

A sync applied part way through a sample, with a byte written while sync is high, shows that stale partial data is discarded.

Filling the FIFO, writing one extra byte, then freeing a single slot shows whether a dropped byte shifted the alignment. The threshold runs cover the flag rising, the flag falling, and the flag changing inside a partly written block.

// File: rtl/pcm_asm_pkg.sv
package pcm_asm_pkg;

  // Clamp a requested bytes-per-sample value into the supported range.
  function automatic int fit_bytes(input int req, input int max_bytes);
    if (req <= 0) return 1;
    if (req > max_bytes) return max_bytes;
    return req;
  endfunction

endpackage

// File: rtl/pcm_byte_sequencer.sv
module pcm_byte_sequencer #(
  parameter int MAX_BYTES = 3,
  parameter int MAX_CHANS = 8,
  parameter int BCW       = $clog2(MAX_BYTES + 1),
  parameter int CHW       = $clog2(MAX_CHANS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sync,
  input  logic           accept,
  input  logic [BCW-1:0] cfg_bytes,
  input  logic [CHW-1:0] chans_m1,
  output logic [BCW-1:0] nbytes,
  output logic [CHW-1:0] chan_idx,
  output logic           last_byte
);

  logic [BCW-1:0] byte_idx;

  assign nbytes    = BCW'(pcm_asm_pkg::fit_bytes(int'(cfg_bytes), MAX_BYTES));
  assign last_byte = (byte_idx >= nbytes - BCW'(1));

  always_ff @(posedge clk) begin
    if (rst || sync) begin
      byte_idx <= '0;
      chan_idx <= '0;
    end else if (accept) begin
      if (last_byte) begin
        byte_idx <= '0;
        chan_idx <= (chan_idx >= chans_m1) ? '0 : chan_idx + CHW'(1);
      end else begin
        byte_idx <= byte_idx + BCW'(1);
      end
    end
  end

  // R1: sync returns the position to the start of channel 0
  a_r1_sync_realign: assert property (@(posedge clk) disable iff (rst)
    sync |=> (byte_idx == '0 && chan_idx == '0));

  // R5: the last byte of the last channel wraps to channel 0
  a_r5_chan_wrap: assert property (@(posedge clk) disable iff (rst)
    (accept && last_byte && chan_idx >= chans_m1) |=> (chan_idx == '0));

endmodule

// File: rtl/pcm_sample_packer.sv
module pcm_sample_packer #(
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 3,
  parameter int BCW       = $clog2(MAX_BYTES + 1),
  parameter int SAMP_W    = BYTE_W * MAX_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync,
  input  logic              accept,
  input  logic              last_byte,
  input  logic [BCW-1:0]    nbytes,
  input  logic [BYTE_W-1:0] din,
  output logic              push,
  output logic [SAMP_W-1:0] push_word
);

  localparam int ACC_W = SAMP_W - BYTE_W;

  logic [ACC_W-1:0]  acc;
  logic [SAMP_W-1:0] joined;
  int                shamt;

  assign joined = {acc, din};
  assign push   = accept && last_byte;

  always_comb begin
    shamt     = BYTE_W * (MAX_BYTES - int'(nbytes));
    push_word = joined << shamt;
  end

  always_ff @(posedge clk) begin
    if (rst || sync) begin
      acc <= '0;
    end else if (accept) begin
      acc <= last_byte ? '0 : joined[ACC_W-1:0];
    end
  end

  // R3: a single-byte sample leaves every bit below the top byte clear
  a_r3_single_byte_low_clear: assert property (@(posedge clk) disable iff (rst)
    (push && nbytes == BCW'(1)) |-> (push_word[SAMP_W-BYTE_W-1:0] == '0));

endmodule

// File: rtl/pcm_sample_fifo.sv
module pcm_sample_fifo #(
  parameter int WIDTH = 27,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_req,
  input  logic [AW:0]      thresh,
  output logic             full,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  output logic             level_flag
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      count;
  logic             pop;

  assign full = (count == (AW+1)'(DEPTH));
  assign pop  = pop_req && (count != '0);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
    if (pop)  rd_data     <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      rd_valid   <= 1'b0;
      level_flag <= 1'b0;
    end else begin
      rd_valid   <= pop;
      level_flag <= (count >= thresh);
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + (AW+1)'(1);
        2'b01:   count <= count - (AW+1)'(1);
        default: count <= count;
      endcase
    end
  end

  // R8: no sample is written into a full FIFO
  a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < (AW+1)'(DEPTH)));

  // R6: a valid read only follows a non-empty FIFO
  a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(count) != '0));

  // R7: flag follows fill against threshold one cycle later
  a_r7_flag_high: assert property (@(posedge clk) disable iff (rst)
    (count >= thresh) |=> level_flag);
  a_r7_flag_low: assert property (@(posedge clk) disable iff (rst)
    (count < thresh) |=> !level_flag);

endmodule

// File: rtl/pcm_stream_assembler.sv
module pcm_stream_assembler #(
  parameter int BYTE_W     = 8,
  parameter int MAX_BYTES  = 3,
  parameter int MAX_CHANS  = 8,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [$clog2(MAX_BYTES+1)-1:0]     cfg_bytes,
  input  logic [$clog2(MAX_CHANS)-1:0]       cfg_chans_m1,
  input  logic [$clog2(FIFO_DEPTH):0]        cfg_thresh,
  input  logic                               sync_ctl,
  input  logic                               wr_en,
  input  logic [BYTE_W-1:0]                  wr_byte,
  input  logic                               rd_en,
  output logic                               rd_valid,
  output logic [BYTE_W*MAX_BYTES-1:0]        rd_sample,
  output logic [$clog2(MAX_CHANS)-1:0]       rd_chan,
  output logic                               level_flag,
  output logic                               overflow
);

  localparam int BCW    = $clog2(MAX_BYTES + 1);
  localparam int CHW    = $clog2(MAX_CHANS);
  localparam int AW     = $clog2(FIFO_DEPTH);
  localparam int SAMP_W = BYTE_W * MAX_BYTES;
  localparam int ENT_W  = CHW + SAMP_W;

  logic             fifo_full, accept, drop, last_byte, push;
  logic [BCW-1:0]   nbytes;
  logic [CHW-1:0]   chan_idx;
  logic [SAMP_W-1:0] push_word;
  logic [ENT_W-1:0] rd_entry;

  assign accept = wr_en && !sync_ctl && !fifo_full;
  assign drop   = wr_en && !sync_ctl && fifo_full;

  pcm_byte_sequencer #(
    .MAX_BYTES(MAX_BYTES), .MAX_CHANS(MAX_CHANS), .BCW(BCW), .CHW(CHW)
  ) u_seq (
    .clk(clk), .rst(rst), .sync(sync_ctl), .accept(accept),
    .cfg_bytes(cfg_bytes), .chans_m1(cfg_chans_m1),
    .nbytes(nbytes), .chan_idx(chan_idx), .last_byte(last_byte)
  );

  pcm_sample_packer #(
    .BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES), .BCW(BCW), .SAMP_W(SAMP_W)
  ) u_pack (
    .clk(clk), .rst(rst), .sync(sync_ctl), .accept(accept),
    .last_byte(last_byte), .nbytes(nbytes), .din(wr_byte),
    .push(push), .push_word(push_word)
  );

  pcm_sample_fifo #(
    .WIDTH(ENT_W), .DEPTH(FIFO_DEPTH), .AW(AW)
  ) u_fifo (
    .clk(clk), .rst(rst), .push(push), .push_data({chan_idx, push_word}),
    .pop_req(rd_en), .thresh(cfg_thresh), .full(fifo_full),
    .rd_valid(rd_valid), .rd_data(rd_entry), .level_flag(level_flag)
  );

  assign rd_chan   = rd_entry[ENT_W-1 -: CHW];
  assign rd_sample = rd_entry[SAMP_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || sync_ctl) overflow <= 1'b0;
    else if (drop)       overflow <= 1'b1;
  end

  // R9: a byte refused for lack of space raises the sticky flag
  a_r9_overflow_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sync_ctl && fifo_full) |=> overflow);
  // R9: sync clears the sticky flag
  a_r9_overflow_clear: assert property (@(posedge clk) disable iff (rst)
    sync_ctl |=> !overflow);

endmodule

// File: tb/sim_pcm_stream_assembler.sv
`timescale 1ns/1ps
module sim_pcm_stream_assembler;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_bytes = 2'd1;
  logic [2:0]  cfg_chans_m1 = 3'd1;
  logic [4:0]  cfg_thresh = 5'd4;
  logic        sync_ctl = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_byte = 8'h00;
  logic        rd_en = 1'b0;
  logic        rd_valid;
  logic [23:0] rd_sample;
  logic [2:0]  rd_chan;
  logic        level_flag;
  logic        overflow;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  pcm_stream_assembler u0 (
    .clk(clk), .rst(rst), .cfg_bytes(cfg_bytes), .cfg_chans_m1(cfg_chans_m1),
    .cfg_thresh(cfg_thresh), .sync_ctl(sync_ctl), .wr_en(wr_en),
    .wr_byte(wr_byte), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_sample(rd_sample), .rd_chan(rd_chan), .level_flag(level_flag),
    .overflow(overflow)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_byte = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_sync();
    @(negedge clk); sync_ctl = 1'b1;
    @(negedge clk); sync_ctl = 1'b0;
  endtask

  task automatic pop_check(input logic [23:0] exp_s, input logic [2:0] exp_c,
                           input string req);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check(rd_valid == 1'b1, {req, " valid"}, 32'(rd_valid), 32'd1);
    check(rd_sample == exp_s, {req, " sample"}, 32'(rd_sample), 32'(exp_s));
    check(rd_chan == exp_c, {req, " chan"}, 32'(rd_chan), 32'(exp_c));
  endtask

  function automatic logic [7:0] bval(input int k, input int s, input int b);
    return 8'((k * 3 + s * 37 + b * 11 + 1) % 256);
  endfunction

  function automatic logic [23:0] exp_word(input int k, input int s, input int nb);
    logic [23:0] w;
    w = '0;
    for (int b = 0; b < nb; b++) w = w | (24'(bval(k, s, b)) << (8 * (2 - b)));
    return w;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(rd_valid == 1'b0, "R10 rd_valid", 32'(rd_valid), 32'd0);
    check(level_flag == 1'b0, "R10 level_flag", 32'(level_flag), 32'd0);
    check(overflow == 1'b0, "R10 overflow", 32'(overflow), 32'd0);
    // R6 / R10: popping the empty FIFO yields nothing
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check(rd_valid == 1'b0, "R6 R10 empty pop", 32'(rd_valid), 32'd0);

    // R2 R3 R4 R5 R6: sweep every width and channel count over two frames
    cfg_thresh = 5'd16;
    for (int nb = 1; nb <= 3; nb++) begin
      for (int ch = 1; ch <= 8; ch++) begin
        int k;
        k = nb * 8 + ch;
        cfg_bytes = 2'(nb);
        cfg_chans_m1 = 3'(ch - 1);
        do_sync();
        for (int s = 0; s < 2 * ch; s++)
          for (int b = 0; b < nb; b++) write_byte(bval(k, s, b));
        for (int s = 0; s < 2 * ch; s++)
          pop_check(exp_word(k, s, nb), 3'(s % ch), "R2 R3 R4 R5 R6 sweep");
      end
    end

    // R2: width code 0 behaves as one byte per sample
    cfg_bytes = 2'd0; cfg_chans_m1 = 3'd1;
    do_sync();
    write_byte(8'hA1); write_byte(8'hB2);
    pop_check(24'hA10000, 3'd0, "R2 code0 left");
    pop_check(24'hB20000, 3'd1, "R2 code0 right");

    // R1: sync mid-sample plus a byte written while sync is high
    cfg_bytes = 2'd3; cfg_chans_m1 = 3'd1;
    do_sync();
    write_byte(8'hEE); write_byte(8'hDD);
    @(negedge clk); sync_ctl = 1'b1; wr_en = 1'b1; wr_byte = 8'h77;
    @(negedge clk); sync_ctl = 1'b0; wr_en = 1'b0;
    write_byte(8'h01); write_byte(8'h02); write_byte(8'h03);
    write_byte(8'h04); write_byte(8'h05); write_byte(8'h06);
    pop_check(24'h010203, 3'd0, "R1 realign left");
    pop_check(24'h040506, 3'd1, "R1 realign right");
    @(negedge clk);
    check(rd_valid == 1'b0, "R1 nothing extra", 32'(rd_valid), 32'd0);

    // R7: threshold crossing up and down, mono 8-bit
    cfg_bytes = 2'd1; cfg_chans_m1 = 3'd0; cfg_thresh = 5'd4;
    do_sync();
    for (int i = 0; i < 3; i++) write_byte(8'(i));
    @(negedge clk);
    check(level_flag == 1'b0, "R7 below threshold", 32'(level_flag), 32'd0);
    write_byte(8'h03);
    @(negedge clk);
    check(level_flag == 1'b1, "R7 at threshold", 32'(level_flag), 32'd1);
    pop_check(24'h000000, 3'd0, "R7 pop");
    @(negedge clk);
    check(level_flag == 1'b0, "R7 falls after pop", 32'(level_flag), 32'd0);
    for (int i = 1; i < 4; i++) pop_check(24'(i) << 16, 3'd0, "R7 drain");

    // R7: flag rises inside a partly written stereo 24-bit block
    cfg_bytes = 2'd3; cfg_chans_m1 = 3'd1; cfg_thresh = 5'd1;
    do_sync();
    write_byte(8'h11); write_byte(8'h22); write_byte(8'h33);
    @(negedge clk);
    check(level_flag == 1'b1, "R7 mid-block rise", 32'(level_flag), 32'd1);
    write_byte(8'h44);
    pop_check(24'h112233, 3'd0, "R7 mid-block pop");
    @(negedge clk);
    check(level_flag == 1'b0, "R7 mid-block fall", 32'(level_flag), 32'd0);
    do_sync();

    // R8 R9: fill to 16 stereo 16-bit samples, drop a byte, check alignment
    cfg_bytes = 2'd2; cfg_chans_m1 = 3'd1; cfg_thresh = 5'd16;
    do_sync();
    for (int s = 0; s < 16; s++)
      for (int b = 0; b < 2; b++) write_byte(8'(8'h40 + s * 2 + b));
    @(negedge clk);
    check(level_flag == 1'b1, "R7 full level", 32'(level_flag), 32'd1);
    check(overflow == 1'b0, "R9 no overflow yet", 32'(overflow), 32'd0);
    write_byte(8'hAA);
    check(overflow == 1'b1, "R9 overflow set", 32'(overflow), 32'd1);
    pop_check(24'h404100, 3'd0, "R8 first out");
    write_byte(8'h12); write_byte(8'h34);
    for (int s = 1; s < 16; s++)
      pop_check({8'(8'h40 + s * 2), 8'(8'h41 + s * 2), 8'h00}, 3'(s % 2), "R8 drain");
    pop_check(24'h123400, 3'd0, "R8 dropped byte kept alignment");
    check(overflow == 1'b1, "R9 overflow sticky", 32'(overflow), 32'd1);
    do_sync();
    check(overflow == 1'b0, "R9 cleared by sync", 32'(overflow), 32'd0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule